// File: doc/BRIEF.md
# Six-Plane Network Message Dispatcher

This block sits between a tile's local proxies and the tile port of a six-plane mesh router. On the way out, a set of proxy sources each offer flits tagged with a message class. The dispatcher works out which physical plane that class travels on, picks one source per plane, and writes the winning flits into a queue for that plane. The router drains each queue over its own valid/ready pair. On the way in, each plane's arriving flits are queued separately. A steering machine then reads the header flit of each packet and hands the whole packet to the proxy that owns its class. A packet whose type is not legal on the plane it arrived on is discarded and flagged.

Each message class has its own plane, so a stalled class can never block another class. This is what keeps protocol deadlock out of the coherence and DMA traffic. The two DMA classes swap their planes when the mode input selects the last-level-cache-coherent model. Every queue applies backpressure through its ready signal and never drops a flit.

Outbound arbitration uses one machine per plane, with states ARB_IDLE and ARB_LOCK. ARB_IDLE grants round-robin. A granted flit that is not a tail causes the transition ARB_IDLE→ARB_LOCK. An accepted tail flit from the owner causes the transition ARB_LOCK→ARB_IDLE. Inbound steering uses one machine per plane, with states ST_IDLE, ST_FWD and ST_DROP. In ST_IDLE, a legal non-tail header causes ST_IDLE→ST_FWD, and an illegal non-tail header causes ST_IDLE→ST_DROP. From ST_FWD or ST_DROP, a consumed tail flit returns the machine to ST_IDLE. A header that is also a tail leaves the machine in ST_IDLE.

Top module: `noc_plane_dispatch`

## Requirements
- R1: Class codes are 0 coherence request, 1 coherence forward, 2 coherence response, 3 DMA device-to-memory, 4 DMA memory-to-device and 5 short message. Plane index p (0..5) stands for plane p+1. Classes 0, 1 and 2 go out on indices 0, 1 and 2, and class 5 goes out on index 4, whatever the mode.
- R2: With `llc_mode` = 0 (non-coherent DMA), class 3 goes out on index 5 and class 4 goes out on index 3.
- R3: With `llc_mode` = 1 (LLC-coherent DMA), class 3 goes out on index 3 and class 4 goes out on index 5.
- R4: Each plane has its own outbound queue. A stalled plane does not stop a source whose class maps to another plane from being accepted and sent.
- R5: Each queue holds QDEPTH flits. When a queue is full, the ready signal toward its producer is low. The head flit stays stable while the consumer is not ready. Flits leave in arrival order, and none is lost.
- R6: When several sources compete for one plane, packets are granted round-robin. Each packet is a run of flits that ends with a flit whose last bit is 1. At most one source is accepted per plane per cycle.
- R7: Once a plane has accepted a packet's header from a source, it takes flits only from that source until the tail flit, so packets are never interleaved.
- R8: An inbound packet's first flit is its header, and header bits [2:0] hold the type, which is a class code. If that class maps to the arrival plane under the current mode, every flit of the packet is delivered in order on that plane's delivery port, with `dlv_dst` equal to the type.
- R9: A header whose type is 6 or 7, or whose class maps to a different plane, causes the whole packet to be consumed with nothing delivered. It also raises `err_drop` for that plane for exactly one cycle.
- R10: After reset, no output valid is high, every inbound ready is high and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llc_mode | input | 1 | 1 selects the LLC-coherent DMA plane mapping |
| src_valid | input | NSRC | Per-source flit valid |
| src_ready | output | NSRC | Per-source flit accepted this cycle |
| src_cls | input | 3*NSRC | Per-source message class |
| src_flit | input | FLIT_W*NSRC | Per-source flit data |
| src_last | input | NSRC | Per-source tail marker |
| tx_valid | output | 6 | Per-plane outbound valid to router |
| tx_ready | input | 6 | Per-plane router ready |
| tx_flit | output | 6*FLIT_W | Per-plane outbound flit |
| tx_last | output | 6 | Per-plane outbound tail marker |
| rx_valid | input | 6 | Per-plane inbound valid from router |
| rx_ready | output | 6 | Per-plane inbound queue not full |
| rx_flit | input | 6*FLIT_W | Per-plane inbound flit |
| rx_last | input | 6 | Per-plane inbound tail marker |
| dlv_valid | output | 6 | Per-plane delivery valid to proxy |
| dlv_ready | input | 6 | Per-plane proxy ready |
| dlv_flit | output | 6*FLIT_W | Per-plane delivered flit |
| dlv_last | output | 6 | Per-plane delivered tail marker |
| dlv_dst | output | 18 | Per-plane destination proxy index (3 bits each) |
| err_drop | output | 6 | Per-plane one-cycle pulse for a dropped packet |

## Verification
If an arbiter were stuck in ARB_LOCK or held the wrong owner, the plane would either stop taking flits or mix two packets. Either fault shows on the `tx` port within the next few flits. If a steering machine were left in ST_DROP or ST_FWD, the next inbound packet would vanish without an error pulse or arrive with the wrong destination, so the fault shows on the first packet after it. A queue count that drifted would either drop ready one flit early or deliver a flit out of order. Both are seen as soon as the queue fills or drains.

// File: rtl/noc_disp_pkg.sv
package noc_disp_pkg;

    localparam int NPLANE = 6;
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_CREQ    = 3'd0,
        CLS_CFWD    = 3'd1,
        CLS_CRSP    = 3'd2,
        CLS_DMA_D2M = 3'd3,
        CLS_DMA_M2D = 3'd4,
        CLS_SHORT   = 3'd5
    } msg_cls_e;

    localparam logic [2:0] PLANE_NONE = 3'd7;

    // Plane index (0..5) carrying a class; the DMA pair swaps with the mode.
    function automatic logic [2:0] plane_of(input logic [CLS_W-1:0] cls,
                                            input logic llc);
        logic [2:0] pl;
        case (cls)
            CLS_CREQ:    pl = 3'd0;
            CLS_CFWD:    pl = 3'd1;
            CLS_CRSP:    pl = 3'd2;
            CLS_DMA_D2M: pl = llc ? 3'd3 : 3'd5;
            CLS_DMA_M2D: pl = llc ? 3'd5 : 3'd3;
            CLS_SHORT:   pl = 3'd4;
            default:     pl = PLANE_NONE;
        endcase
        return pl;
    endfunction

endpackage

// File: rtl/disp_fifo.sv
module disp_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          push, pop;

    assign in_ready  = (cnt_q != (AW+1)'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rp_q];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (AW+1)'(DEPTH)) else $error("queue count beyond depth"); // R5
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data))
        else $error("queue head changed under backpressure"); // R5

endmodule

// File: rtl/disp_plane_arb.sv
module disp_plane_arb #(
    parameter int NSRC = 4,
    parameter int W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_new,
    input  logic [NSRC-1:0]   src_valid,
    input  logic [NSRC-1:0]   src_last,
    input  logic [NSRC*W-1:0] src_flit,
    input  logic              fifo_ready,
    output logic [NSRC-1:0]   take,
    output logic              push,
    output logic [W-1:0]      push_flit,
    output logic              push_last,
    output logic [NSRC-1:0]   lock_mask
);
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef enum logic {ARB_IDLE, ARB_LOCK} arb_state_e;

    arb_state_e    state_q, state_d;
    logic [SW-1:0] owner_q, owner_d, ptr_q, ptr_d;
    logic [SW-1:0] pick, sel;
    logic          pick_ok, sel_ok;

    // Round-robin search starting just after the last granted source.
    always_comb begin
        pick    = '0;
        pick_ok = 1'b0;
        for (int k = 1; k <= NSRC; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % NSRC;
            if (!pick_ok && req_new[idx]) begin
                pick_ok = 1'b1;
                pick    = SW'(idx);
            end
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ARB_IDLE: begin sel = pick;    sel_ok = pick_ok;            end
            ARB_LOCK: begin sel = owner_q; sel_ok = src_valid[owner_q]; end
            default:  begin sel = '0;      sel_ok = 1'b0;               end
        endcase
        push      = sel_ok && fifo_ready;
        take      = '0;
        take[sel] = push;
        push_flit = src_flit[sel*W +: W];
        push_last = src_last[sel];
        lock_mask = '0;
        if (state_q == ARB_LOCK) lock_mask[owner_q] = 1'b1;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ARB_IDLE: if (push) begin
                ptr_d = sel;
                if (!push_last) begin
                    state_d = ARB_LOCK;
                    owner_d = sel;
                end
            end
            ARB_LOCK: if (push && push_last) state_d = ARB_IDLE;
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            ptr_q   <= SW'(NSRC - 1);
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take)) else $error("two sources accepted on one plane"); // R6
    AST_HEAD_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        push && !push_last |=> lock_mask != '0)
        else $error("non-tail flit did not lock the plane"); // R7

endmodule

// File: rtl/disp_rx_steer.sv
module disp_rx_steer
    import noc_disp_pkg::*;
#(
    parameter int W     = 16,
    parameter int PLANE = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         llc_mode,
    input  logic         head_valid,
    input  logic [W-1:0] head_flit,
    input  logic         head_last,
    output logic         pop,
    input  logic         dlv_ready,
    output logic         dlv_valid,
    output logic [W-1:0] dlv_flit,
    output logic         dlv_last,
    output logic [2:0]   dlv_dst,
    output logic         err
);
    typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_DROP} steer_state_e;

    steer_state_e state_q, state_d;
    logic [2:0]   dst_q, dst_d;
    logic [2:0]   hdr_cls;
    logic         hdr_ok;

    assign hdr_cls  = head_flit[2:0];
    assign hdr_ok   = (plane_of(hdr_cls, llc_mode) == 3'(PLANE));
    assign dlv_flit = head_flit;
    assign dlv_last = head_last;

    // Outputs.
    always_comb begin
        dlv_valid = 1'b0;
        dlv_dst   = dst_q;
        pop       = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE: if (head_valid) begin
                if (hdr_ok) begin
                    dlv_valid = 1'b1;
                    dlv_dst   = hdr_cls;
                    pop       = dlv_ready;
                end else begin
                    pop = 1'b1;
                    err = 1'b1;
                end
            end
            ST_FWD: begin
                dlv_valid = head_valid;
                pop       = head_valid && dlv_ready;
            end
            ST_DROP: pop = head_valid;
            default: ;
        endcase
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        dst_d   = dst_q;
        unique case (state_q)
            ST_IDLE: if (pop && !head_last) begin
                state_d = hdr_ok ? ST_FWD : ST_DROP;
                dst_d   = hdr_cls;
            end
            ST_FWD:  if (pop && head_last) state_d = ST_IDLE;
            ST_DROP: if (pop && head_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            dst_q   <= dst_d;
        end
    end

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !dlv_valid) else $error("dropped header was delivered"); // R9
    AST_DLV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_flit) && $stable(dlv_dst))
        else $error("delivery changed under backpressure"); // R8

endmodule

// File: rtl/noc_plane_dispatch.sv
module noc_plane_dispatch
    import noc_disp_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int FLIT_W = 16,
    parameter int QDEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     llc_mode,
    input  logic [NSRC-1:0]          src_valid,
    output logic [NSRC-1:0]          src_ready,
    input  logic [NSRC*CLS_W-1:0]    src_cls,
    input  logic [NSRC*FLIT_W-1:0]   src_flit,
    input  logic [NSRC-1:0]          src_last,
    output logic [NPLANE-1:0]        tx_valid,
    input  logic [NPLANE-1:0]        tx_ready,
    output logic [NPLANE*FLIT_W-1:0] tx_flit,
    output logic [NPLANE-1:0]        tx_last,
    input  logic [NPLANE-1:0]        rx_valid,
    output logic [NPLANE-1:0]        rx_ready,
    input  logic [NPLANE*FLIT_W-1:0] rx_flit,
    input  logic [NPLANE-1:0]        rx_last,
    output logic [NPLANE-1:0]        dlv_valid,
    input  logic [NPLANE-1:0]        dlv_ready,
    output logic [NPLANE*FLIT_W-1:0] dlv_flit,
    output logic [NPLANE-1:0]        dlv_last,
    output logic [NPLANE*3-1:0]      dlv_dst,
    output logic [NPLANE-1:0]        err_drop
);
    localparam int QW = FLIT_W + 1;

    logic [NSRC-1:0] take_pl [NPLANE];
    logic [NSRC-1:0] lock_pl [NPLANE];
    logic [NSRC-1:0] busy_all;

    // A source owned by a locked plane may not open a packet on another one.
    always_comb begin
        busy_all  = '0;
        src_ready = '0;
        for (int p = 0; p < NPLANE; p++) begin
            busy_all  = busy_all | lock_pl[p];
            src_ready = src_ready | take_pl[p];
        end
    end

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [NSRC-1:0]   req_new;
        logic              ofifo_ready, opush, opush_last;
        logic [FLIT_W-1:0] opush_flit;
        logic [QW-1:0]     odata, idata;
        logic              ihead_valid, ipop;

        always_comb begin
            for (int i = 0; i < NSRC; i++) begin
                req_new[i] = src_valid[i] && !busy_all[i] &&
                             (plane_of(src_cls[i*CLS_W +: CLS_W], llc_mode) == 3'(p));
            end
        end

        disp_plane_arb #(.NSRC(NSRC), .W(FLIT_W)) u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_new    (req_new),
            .src_valid  (src_valid),
            .src_last   (src_last),
            .src_flit   (src_flit),
            .fifo_ready (ofifo_ready),
            .take       (take_pl[p]),
            .push       (opush),
            .push_flit  (opush_flit),
            .push_last  (opush_last),
            .lock_mask  (lock_pl[p])
        );

        disp_fifo #(.W(QW), .DEPTH(QDEPTH)) u_out_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (opush),
            .in_ready  (ofifo_ready),
            .in_data   ({opush_last, opush_flit}),
            .out_valid (tx_valid[p]),
            .out_ready (tx_ready[p]),
            .out_data  (odata)
        );

        assign tx_last[p]                  = odata[FLIT_W];
        assign tx_flit[p*FLIT_W +: FLIT_W] = odata[FLIT_W-1:0];

        disp_fifo #(.W(QW), .DEPTH(QDEPTH)) u_in_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (rx_valid[p]),
            .in_ready  (rx_ready[p]),
            .in_data   ({rx_last[p], rx_flit[p*FLIT_W +: FLIT_W]}),
            .out_valid (ihead_valid),
            .out_ready (ipop),
            .out_data  (idata)
        );

        disp_rx_steer #(.W(FLIT_W), .PLANE(p)) u_steer (
            .clk        (clk),
            .rst_n      (rst_n),
            .llc_mode   (llc_mode),
            .head_valid (ihead_valid),
            .head_flit  (idata[FLIT_W-1:0]),
            .head_last  (idata[FLIT_W]),
            .pop        (ipop),
            .dlv_ready  (dlv_ready[p]),
            .dlv_valid  (dlv_valid[p]),
            .dlv_flit   (dlv_flit[p*FLIT_W +: FLIT_W]),
            .dlv_last   (dlv_last[p]),
            .dlv_dst    (dlv_dst[p*3 +: 3]),
            .err        (err_drop[p])
        );
    end

endmodule

// File: tb/noc_plane_dispatch_test.sv
`timescale 1ns/100ps
module noc_plane_dispatch_test;
    localparam int NSRC = 4;
    localparam int W    = 16;
    localparam int QD   = 4;
    localparam int NP   = 6;

    // {llc_mode, class, expected plane index}
    localparam int VEC [12][3] = '{
        '{0,0,0}, '{0,1,1}, '{0,2,2}, '{0,3,5}, '{0,4,3}, '{0,5,4},
        '{1,0,0}, '{1,1,1}, '{1,2,2}, '{1,3,3}, '{1,4,5}, '{1,5,4}};

    logic clk = 0, rst_n = 0, llc_mode = 0;
    always #2.5 clk = ~clk;

    logic         s_valid [NSRC];
    logic [2:0]   s_cls   [NSRC];
    logic [W-1:0] s_flit  [NSRC];
    logic         s_last  [NSRC];
    logic         r_valid [NP];
    logic [W-1:0] r_flit  [NP];
    logic         r_last  [NP];

    logic [NSRC-1:0] src_valid, src_ready, src_last;
    logic [NSRC*3-1:0] src_cls;
    logic [NSRC*W-1:0] src_flit;
    logic [NP-1:0] tx_valid, tx_ready, tx_last, rx_valid, rx_ready, rx_last;
    logic [NP-1:0] dlv_valid, dlv_ready, dlv_last, err_drop;
    logic [NP*W-1:0] tx_flit, rx_flit, dlv_flit;
    logic [NP*3-1:0] dlv_dst;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            src_valid[i] = s_valid[i];
            src_cls[i*3 +: 3] = s_cls[i];
            src_flit[i*W +: W] = s_flit[i];
            src_last[i] = s_last[i];
        end
        for (int p = 0; p < NP; p++) begin
            rx_valid[p] = r_valid[p];
            rx_flit[p*W +: W] = r_flit[p];
            rx_last[p] = r_last[p];
        end
    end

    noc_plane_dispatch #(.NSRC(NSRC), .FLIT_W(W), .QDEPTH(QD)) uut (
        .clk(clk), .rst_n(rst_n), .llc_mode(llc_mode),
        .src_valid(src_valid), .src_ready(src_ready), .src_cls(src_cls),
        .src_flit(src_flit), .src_last(src_last),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_flit(rx_flit), .rx_last(rx_last),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_flit(dlv_flit),
        .dlv_last(dlv_last), .dlv_dst(dlv_dst), .err_drop(err_drop));

    int checks = 0, errors = 0;
    bit finished = 0;
    int tx_f [1024]; int tx_p [1024]; int tx_n = 0;
    int dl_f [256]; int dl_d [256]; int dl_l [256]; int dl_p [256]; int dl_n = 0;
    int err_n = 0;

    // Record each transfer that the next rising edge will complete.
    always begin
        @(negedge clk); #2;
        for (int p = 0; p < NP; p++) begin
            if (tx_valid[p] && tx_ready[p]) begin
                tx_f[tx_n] = int'(tx_flit[p*W +: W]); tx_p[tx_n] = p; tx_n++;
            end
            if (dlv_valid[p] && dlv_ready[p]) begin
                dl_f[dl_n] = int'(dlv_flit[p*W +: W]); dl_d[dl_n] = int'(dlv_dst[p*3 +: 3]);
                dl_l[dl_n] = int'(dlv_last[p]); dl_p[dl_n] = p; dl_n++;
            end
            if (err_drop[p]) err_n++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input int s, input int cls, input int f, input bit last);
        bit done = 0;
        @(negedge clk);
        s_valid[s] = 1; s_cls[s] = 3'(cls); s_flit[s] = W'(f); s_last[s] = last;
        while (!done) begin
            #1;
            if (src_ready[s]) done = 1;
            @(posedge clk);
            if (!done) @(negedge clk);
        end
        #1 s_valid[s] = 0;
    endtask

    task automatic rx_send(input int p, input int f, input bit last);
        bit done = 0;
        @(negedge clk);
        r_valid[p] = 1; r_flit[p] = W'(f); r_last[p] = last;
        while (!done) begin
            #1;
            if (rx_ready[p]) done = 1;
            @(posedge clk);
            if (!done) @(negedge clk);
        end
        #1 r_valid[p] = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R10 watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int mark, dmark, emark, q, pos;
        int seq [8];
        for (int i = 0; i < NSRC; i++) begin
            s_valid[i] = 0; s_cls[i] = 0; s_flit[i] = 0; s_last[i] = 0;
        end
        for (int p = 0; p < NP; p++) begin
            r_valid[p] = 0; r_flit[p] = 0; r_last[p] = 0;
        end
        tx_ready = '1; dlv_ready = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R10 tx_valid after reset", int'(tx_valid), 0);
        chk("R10 dlv_valid after reset", int'(dlv_valid), 0);
        chk("R10 rx_ready after reset", int'(rx_ready), 6'h3f);
        chk("R10 err_drop after reset", int'(err_drop), 0);

        // Plane mapping table (R1, R2, R3).
        for (int i = 0; i < 12; i++) begin
            string tg;
            tg = (VEC[i][1] == 3 || VEC[i][1] == 4) ?
                 (VEC[i][0] != 0 ? "R3 llc dma plane" : "R2 noncoh dma plane") : "R1 class plane";
            @(negedge clk); llc_mode = VEC[i][0][0];
            mark = tx_n;
            send(0, VEC[i][1], 16'h100 + i, 1);
            repeat (3) @(negedge clk);
            chk(tg, tx_n - mark, 1);
            chk(tg, tx_p[mark], VEC[i][2]);
        end

        // R5 full queue / R4 plane independence.
        @(negedge clk); llc_mode = 0; tx_ready[0] = 0;
        mark = tx_n;
        for (int k = 0; k < QD; k++) send(0, 0, 16'h200 + k, 1);
        @(negedge clk);
        s_valid[0] = 1; s_cls[0] = 0; s_flit[0] = 16'h204; s_last[0] = 1;
        s_valid[1] = 1; s_cls[1] = 5; s_flit[1] = 16'h300; s_last[1] = 1;
        #1;
        chk("R5 full queue ready low", int'(src_ready[0]), 0);
        chk("R4 other plane still ready", int'(src_ready[1]), 1);
        @(posedge clk); #1 s_valid[0] = 0; s_valid[1] = 0;
        repeat (3) @(negedge clk);
        chk("R4 short message sent past stall", tx_n - mark, 1);
        chk("R4 short message plane", tx_p[mark], 4);
        chk("R4 short message flit", tx_f[mark], 16'h300);
        chk("R5 head held valid", int'(tx_valid[0]), 1);
        chk("R5 head held data", int'(tx_flit[W-1:0]), 16'h200);
        tx_ready[0] = 1;
        repeat (6) @(negedge clk);
        send(0, 0, 16'h204, 1);
        repeat (3) @(negedge clk);
        q = 0;
        for (int j = mark; j < tx_n; j++) if (tx_p[j] == 0) begin
            chk("R5 order kept", tx_f[j], 16'h200 + q); q++;
        end
        chk("R5 no flit lost", q, QD + 1);

        // R6 round-robin on plane index 2.
        @(negedge clk); mark = tx_n;
        fork
            begin send(0, 2, 16'h400, 1); send(0, 2, 16'h401, 1); end
            begin send(1, 2, 16'h410, 1); send(1, 2, 16'h411, 1); end
            begin send(2, 2, 16'h420, 1); send(2, 2, 16'h421, 1); end
        join
        repeat (4) @(negedge clk);
        q = 0;
        for (int j = mark; j < tx_n; j++) if (tx_p[j] == 2 && q < 8) begin
            seq[q] = (tx_f[j] >> 4) & 15; q++;
        end
        chk("R6 flit count", q, 6);
        chk("R6 each source once per round", (1 << seq[0]) | (1 << seq[1]) | (1 << seq[2]), 7);
        for (int j = 0; j < 3; j++) chk("R6 rotation repeats", seq[j + 3], seq[j]);

        // R7 packet lock on plane index 0.
        @(negedge clk); mark = tx_n;
        fork
            begin send(0, 0, 16'h500, 0); send(0, 0, 16'h501, 0); send(0, 0, 16'h502, 1); end
            begin for (int n = 0; n < 4; n++) send(1, 0, 16'h510 + n, 1); end
        join
        repeat (4) @(negedge clk);
        q = 0; pos = -1;
        for (int j = mark; j < tx_n; j++) if (tx_p[j] == 0) begin
            if (tx_f[j] == 16'h500) pos = j;
            q++;
        end
        chk("R7 flit count", q, 7);
        chk("R7 header seen", int'(pos >= 0), 1);
        if (pos >= 0) begin
            chk("R7 body follows header", tx_f[pos + 1], 16'h501);
            chk("R7 tail follows body", tx_f[pos + 2], 16'h502);
        end

        // R8 inbound steering.
        @(negedge clk); llc_mode = 0; dmark = dl_n;
        rx_send(0, 16'h0A0, 0); rx_send(0, 16'h0A1, 1);
        repeat (3) @(negedge clk);
        chk("R8 two flits delivered", dl_n - dmark, 2);
        chk("R8 dst coherence request", dl_d[dmark], 0);
        chk("R8 body flit", dl_f[dmark + 1], 16'h0A1);
        chk("R8 tail marker", dl_l[dmark + 1], 1);
        dmark = dl_n;
        rx_send(4, 16'h0C5, 1);
        repeat (3) @(negedge clk);
        chk("R8 short message dst", dl_d[dmark], 5);
        chk("R8 short message plane", dl_p[dmark], 4);
        dmark = dl_n;
        rx_send(5, 16'h0B3, 1);
        repeat (3) @(negedge clk);
        chk("R8 noncoh dma dst", dl_d[dmark], 3);
        @(negedge clk); llc_mode = 1; dmark = dl_n;
        rx_send(3, 16'h0D3, 1);
        repeat (3) @(negedge clk);
        chk("R8 llc dma delivered", dl_n - dmark, 1);
        chk("R8 llc dma plane", dl_p[dmark], 3);

        // R9 drop of unknown or misplaced type.
        @(negedge clk); llc_mode = 0; dmark = dl_n; emark = err_n;
        rx_send(0, 16'h0E7, 0); rx_send(0, 16'h0E8, 0); rx_send(0, 16'h0E9, 1);
        repeat (3) @(negedge clk);
        chk("R9 unknown type one pulse", err_n - emark, 1);
        chk("R9 unknown packet not delivered", dl_n - dmark, 0);
        rx_send(0, 16'h0F1, 1);
        repeat (3) @(negedge clk);
        chk("R9 misplaced type pulse", err_n - emark, 2);
        chk("R9 misplaced not delivered", dl_n - dmark, 0);
        rx_send(0, 16'h0F0, 1);
        repeat (3) @(negedge clk);
        chk("R9 next packet delivered", dl_n - dmark, 1);
        chk("R9 next packet flit", dl_f[dmark], 16'h0F0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule